// File: doc/BRIEF.md
# Token-Ring Polling Readout Manager

This controller moves event data out of a row of per-channel event buffers. It does so by passing a single one-hot token around the channels in a fixed ascending order. Every channel reports only an empty flag. When at least one buffer becomes non-empty, the manager waits a fixed settling delay and then starts a traversal at channel 0.

The token stays on each channel for one polling slot of `SLOT_CYC` main-clock cycles. With the defaults this is 4 cycles of 128 MHz, about 31 ns, so one pass over 16 channels takes 500 ns. A slot lasts the same time whether the channel holds data or not. If the channel holds data, a one-cycle read strobe goes to that channel at the start of the slot, and a data-valid flag marks the packet cycles. The shared output bus keeps its last value between reads, so only the valid flag tells downstream acquisition that data is fresh.

The token vector itself selects the inputs of the channel output multiplexers, so two channels can never drive the bus at once. A binary form of the same selection is also provided. At the end of a traversal, the manager starts again at channel 0 if any buffer still holds data. Otherwise it returns to idle, and the next arrival restarts the settling delay.

Top module: `tr_poll_mgr`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `token`, `rd_stb`, `data_valid`, `busy` and `mux_sel` are all zero.
- R2: While every bit of `ch_empty` is high and the manager is idle, `token` stays zero and `busy` stays low.
- R3: The first clock edge that sees any `ch_empty` bit low (in idle) starts the settling delay. `token` becomes non-zero exactly `START_DLY` (default 20) clocks after that edge.
- R4: `token` is always one-hot or zero. A traversal starts with bit 0 set, and each step moves the set bit from channel k to channel k+1.
- R5: The token stays on every channel for exactly `SLOT_CYC` (default 4) clocks, whether that channel is empty or not, so one traversal takes `NUM_CH*SLOT_CYC` clocks.
- R6: `rd_stb[k]` is a single-cycle pulse in the first clock of channel k's slot. It is issued only if `ch_empty[k]` was low at the edge that started the slot. No strobe ever reaches an empty channel, and at most one strobe bit is high at a time.
- R7: `data_valid` is high for exactly `PKT_CYC` (default 4, at most `SLOT_CYC`) clocks starting with each read strobe, and is low at all other times.
- R8: While the token is held, `mux_sel` equals the binary index of the set token bit.
- R9: At the end of the last channel's slot, the manager starts a new traversal at channel 0 if any `ch_empty` bit is low. Otherwise it drops the token and returns to idle.
- R10: `busy` is high from the clock after the delay is started until the clock after the manager returns to idle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (128 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| ch_empty | input | NUM_CH | Per-channel buffer empty flags, bit k for channel k |
| token | output | NUM_CH | One-hot token, also the contention-free multiplexer select |
| rd_stb | output | NUM_CH | Per-channel one-cycle read strobes |
| mux_sel | output | $clog2(NUM_CH) | Binary index of the channel holding the token |
| data_valid | output | 1 | High during the packet cycles of a read |
| busy | output | 1 | High while delaying or polling |

## Verification
The hardest case to create from the ports is an event that arrives on a channel the token has already passed in the current traversal. Only that case makes the end-of-pass decision wrap back to channel 0 instead of going idle. The bench models each buffer as an event counter that read strobes drain. It injects an event into channel 0 partway through a pass that was started by channel 5. It then checks that exactly one extra traversal follows and that it reads channel 0. Table rows with several events per channel also exercise back-to-back wraps and strobes in adjacent slots.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_POLL = 2'd2
  } tr_state_e;
endpackage

// File: rtl/tr_start_delay.sv
module tr_start_delay #(
  parameter int DLY = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic done
);
  localparam int W = (DLY < 2) ? 1 : $clog2(DLY + 1);
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = arm && (cnt == LAST);

  // R3
  wait_count_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !done) |=> (!arm || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tr_slot_timer.sv
module tr_slot_timer #(
  parameter int SLOT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic [((SLOT_CYC < 2) ? 1 : $clog2(SLOT_CYC))-1:0] slot_pos,
  output logic slot_end
);
  localparam int SW = (SLOT_CYC < 2) ? 1 : $clog2(SLOT_CYC);
  localparam logic [SW-1:0] LAST = SW'(SLOT_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) slot_pos <= '0;
    else if (run) slot_pos <= (slot_pos == LAST) ? '0 : slot_pos + 1'b1;
  end

  assign slot_end = (slot_pos == LAST);

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !slot_end) |=> (slot_pos == $past(slot_pos) + 1'b1));
endmodule

// File: rtl/tr_token_ring.sv
module tr_token_ring #(
  parameter int NUM_CH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_first,
  input  logic                      advance,
  input  logic                      clear,
  output logic [NUM_CH-1:0]         token,
  output logic [NUM_CH-1:0]         next_token,
  output logic [$clog2(NUM_CH)-1:0] idx,
  output logic                      at_last
);
  localparam int CW = $clog2(NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    if (i == 0) begin : g_head
      always_comb begin
        if (load_first)   next_token[i] = 1'b1;
        else if (clear)   next_token[i] = 1'b0;
        else if (advance) next_token[i] = 1'b0;
        else              next_token[i] = token[i];
      end
    end else begin : g_tail
      always_comb begin
        if (load_first)   next_token[i] = 1'b0;
        else if (clear)   next_token[i] = 1'b0;
        else if (advance) next_token[i] = token[i-1];
        else              next_token[i] = token[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) token <= '0;
    else     token <= next_token;
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (token[k]) idx = idx | CW'(k);
  end

  assign at_last = token[NUM_CH-1];

  // R4
  token_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(token));
  // R4
  token_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> (token == ($past(token) << 1)));
endmodule

// File: rtl/tr_poll_mgr.sv
module tr_poll_mgr #(
  parameter int NUM_CH    = 16,
  parameter int SLOT_CYC  = 4,
  parameter int START_DLY = 20,
  parameter int PKT_CYC   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         ch_empty,
  output logic [NUM_CH-1:0]         token,
  output logic [NUM_CH-1:0]         rd_stb,
  output logic [$clog2(NUM_CH)-1:0] mux_sel,
  output logic                      data_valid,
  output logic                      busy
);
  import tr_pkg::*;

  localparam int SW = (SLOT_CYC < 2) ? 1 : $clog2(SLOT_CYC);

  if (PKT_CYC < 1 || PKT_CYC > SLOT_CYC) begin : g_bad_pkt
    $error("PKT_CYC must lie between 1 and SLOT_CYC");
  end

  tr_state_e         state, state_nx;
  logic              any_ne, dly_done, slot_end, at_last, hit;
  logic              end_poll, load_first, advance, clear, load, hit_next;
  logic [SW-1:0]     slot_pos;
  logic [NUM_CH-1:0] next_token;

  assign any_ne     = ~&ch_empty;
  assign end_poll   = (state == ST_POLL) && slot_end;
  assign load_first = ((state == ST_ARM) && dly_done) || (end_poll && at_last && any_ne);
  assign advance    = end_poll && !at_last;
  assign clear      = end_poll && at_last && !any_ne;
  assign load       = load_first || advance;
  assign hit_next   = |(next_token & ~ch_empty);

  tr_start_delay #(.DLY(START_DLY)) u_dly (
    .clk(clk), .rst(rst), .arm(state == ST_ARM), .done(dly_done)
  );

  tr_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_slot (
    .clk(clk), .rst(rst), .run(state == ST_POLL), .restart(load),
    .slot_pos(slot_pos), .slot_end(slot_end)
  );

  tr_token_ring #(.NUM_CH(NUM_CH)) u_ring (
    .clk(clk), .rst(rst), .load_first(load_first), .advance(advance),
    .clear(clear), .token(token), .next_token(next_token),
    .idx(mux_sel), .at_last(at_last)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (any_ne)   state_nx = ST_ARM;
      ST_ARM:  if (dly_done) state_nx = ST_POLL;
      ST_POLL: if (clear)    state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rd_stb     <= '0;
      hit        <= 1'b0;
      data_valid <= 1'b0;
      busy       <= 1'b0;
    end else begin
      state <= state_nx;
      busy  <= (state_nx != ST_IDLE);
      if (load) begin
        rd_stb     <= next_token & ~ch_empty;
        hit        <= hit_next;
        data_valid <= hit_next;
      end else begin
        rd_stb     <= '0;
        if (clear) hit <= 1'b0;
        data_valid <= hit && (state == ST_POLL) && !clear &&
                      ((int'(slot_pos) + 1) < PKT_CYC);
      end
    end
  end

  // R3
  no_early_token_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && any_ne) |=> (token == '0 && busy));
  // R6
  rd_in_token_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb != '0) |-> ((rd_stb & ~token) == '0));
  // R6
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_stb));
  // R6
  rd_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb != '0) |-> (($past(ch_empty) & rd_stb) == '0));
  // R7
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> busy);
  // R7
  valid_starts_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> (rd_stb != '0));
  // R9
  idle_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (token == '0 && rd_stb == '0 && !data_valid));
  // R10
  busy_token_chk: assert property (@(posedge clk) disable iff (rst)
    (token != '0) |-> busy);
endmodule

// File: tb/tb_tr_poll_mgr.sv
module tb_tr_poll_mgr;
  localparam int N    = 16;
  localparam int SLOT = 4;
  localparam int DLY  = 20;
  localparam int PKT  = 4;
  localparam int NV   = 6;
  // two bits of pending-event count per channel, channel k in bits 2k+1:2k
  localparam logic [31:0] VECS [NV] = '{
    32'h0000_0001, 32'h4000_0000, 32'h5555_5555,
    32'h0000_4080, 32'h3333_3333, 32'h0009_0000
  };

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] ch_empty, token, rd_stb;
  logic [$clog2(N)-1:0] mux_sel;
  logic data_valid, busy;
  int evq [N];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) ch_empty[i] = (evq[i] == 0);

  tr_poll_mgr #(.NUM_CH(N), .SLOT_CYC(SLOT), .START_DLY(DLY), .PKT_CYC(PKT)) dut (
    .clk(clk), .rst(rst), .ch_empty(ch_empty), .token(token), .rd_stb(rd_stb),
    .mux_sel(mux_sel), .data_valid(data_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(token == '0 && rd_stb == '0 && !data_valid && !busy && mux_sel == '0,
        req, int'(token), 0);
  endtask

  task automatic run_case(input logic [31:0] vec, input int inj_n, input int inj_ch,
                          input int extra_trav);
    int sum = 0, mx = 0, first_tok = 0, busy_cnt = 0, reads = 0, vcnt = 0;
    int e_oh = 0, e_seq = 0, e_dw = 0, e_mux = 0, e_rd = 0, e_val = 0, run_len = 0;
    int exp_reads, exp_trav, sel;
    logic [N-1:0] prev = '0;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      evq[i] = int'(vec[2*i +: 2]);
      sum += evq[i];
      if (evq[i] > mx) mx = evq[i];
    end
    exp_reads = sum + ((inj_n > 0) ? 1 : 0);
    exp_trav  = mx + extra_trav;
    for (int n = 1; n < 4000; n++) begin
      @(negedge clk);
      if (token != '0 && first_tok == 0) first_tok = n;
      if (busy) busy_cnt++;
      if (!$onehot0(token)) e_oh++;
      sel = 0;
      for (int i = 0; i < N; i++) if (token[i]) sel = i;
      if (token != '0 && int'(mux_sel) != sel) e_mux++;
      if (token != prev) begin
        if (prev != '0 && run_len != SLOT) e_dw++;
        if (token != '0 && !((token == 1 && (prev == '0 || prev[N-1])) || token == (prev << 1)))
          e_seq++;
        run_len = 1;
      end else run_len++;
      prev = token;
      if (rd_stb != '0) begin
        reads++;
        if (!data_valid) e_val++;
        for (int i = 0; i < N; i++)
          if (rd_stb[i]) begin
            if (evq[i] == 0) e_rd++;
            else evq[i]--;
          end
      end
      if (data_valid) vcnt++;
      if (n == inj_n) evq[inj_ch]++;
      if (!busy) break;
    end
    chk(first_tok == DLY + 1, "R3 start delay", first_tok, DLY + 1);
    chk(e_oh == 0 && e_seq == 0, "R4 one-hot ascending token", e_oh + e_seq, 0);
    chk(e_dw == 0, "R5 slot dwell", e_dw, 0);
    chk(e_rd == 0, "R6 strobe on empty channel", e_rd, 0);
    chk(reads == exp_reads, "R6 read count", reads, exp_reads);
    chk(vcnt == PKT * exp_reads && e_val == 0, "R7 valid cycles", vcnt, PKT * exp_reads);
    chk(e_mux == 0, "R8 mux select", e_mux, 0);
    chk(busy_cnt == DLY + SLOT * N * exp_trav, "R9 R10 busy span / traversals",
        busy_cnt, DLY + SLOT * N * exp_trav);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seen;
    for (int i = 0; i < N; i++) evq[i] = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R1 outputs during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_quiet("R1 outputs after reset");

    // R2: idle with every buffer empty
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (token != '0 || busy) seen++;
    end
    chk(seen == 0, "R2 idle while empty", seen, 0);

    for (int v = 0; v < NV; v++) run_case(VECS[v], 0, 0, 0);

    // R9: late arrival on channel 0 after the token passed it forces one more pass
    run_case(32'h0000_0400, 30, 0, 1);

    // R1: reset in the middle of polling
    @(negedge clk);
    evq[2] = 1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_quiet("R1 mid-run reset");
    evq[2] = 0;
    rst = 1'b0;
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (token != '0 || busy) seen++;
    end
    chk(seen == 0, "R2 quiet after reset", seen, 0);
    run_case(32'h0000_0001, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule